// File: doc/BRIEF.md
# SCSI Controller Host Register Front-End

This block is the processor-facing side of a small SCSI protocol controller. A byte-wide register bus reaches sixteen register slots. A write and a read to the same slot can reach different storage: the write side holds what software programmed, and the read side shows the state of the controller. A sixteen-byte data FIFO is reached through one slot. A command byte written to the command slot is decoded here. Commands that need no bus activity run locally: no-op, FIFO flush, chip reset, bus reset, and set or clear of the attention flag.

Selection, transfer, status-collection and message-accept commands are passed on to an external bus sequencer. The block raises a one-cycle start strobe with the command byte, and the sequencer later reports completion through a done strobe with a fail flag, a phase and a step value. The block keeps the interrupt, status and step registers and drives a level interrupt output. The sequencer has its own push and pop port on the FIFO. A mode input picks word-spaced addressing, where the slot is the byte address divided by four, or byte-spaced addressing, where the slot equals the address.

Top module: `scsi_regfront`

## Requirements
- R1: After reset, reads return 0x00 from slots 0, 1, 4, 5 and 6, 0x94 from slot 14, 0x02 from slot 9 and 0x07 from slot 8. The irq, atn and fifo_err outputs are low.
- R2: Slots 3 and 8 to 12 read back the last byte written, except that bits 2:0 of slot 8 always read 7. With addr_mode=1 the slot is the address divided by 4 and the two low address bits are ignored. With addr_mode=0 the slot equals the address.
- R3: Slot 2 is a 16-deep first-in first-out byte queue shared with the sequencer port. A bus read of an empty queue returns 0x00. Sequencer push and pop are ignored in a cycle where the bus accesses slot 2.
- R4: A push to a full queue or a pop from an empty one leaves the stored bytes and the count unchanged and sets fifo_err, which stays set until chip reset.
- R5: Slot 7 reads {step[2:0], count[4:0]}, where count is the number of bytes in the queue.
- R6: Command 0x01 empties the queue.
- R7: Command 0x02 restores the R1 state, empties the queue and clears atn and fifo_err.
- R8: A command byte with bit 7 set copies the write-side count bytes from slots 0, 1 and 14 to their read sides and clears status bit 4 (terminal count). Before that, the read sides keep their old values.
- R9: Command 0x03 sets interrupt bits 7 (bus reset) and 3 (function complete) and clears connected. It sets status bit 7 and irq only when bit 6 of slot 8 is clear.
- R10: Every command write first clears interrupt bit 7. A command code outside the known set sets interrupt bit 6 (illegal) and raises irq.
- R11: Command 0x1A sets atn and 0x1B clears it.
- R12: Codes 0x10, 0x11, 0x12, 0x18, 0x41, 0x42, 0x43 and 0x46 (bit 7 free) pulse seq_start for exactly the cycle after the write, with seq_cmd holding the full byte and seq_target holding bits 2:0 of the slot 4 write side.
- R13: seq_done with seq_fail clear sets connected, status bit 7, interrupt bits 4 and 3, status[2:0]=seq_phase and step=seq_step. With seq_tc also set, it sets status bit 4 and zeroes the read side of slots 0 and 1. seq_done with seq_fail set clears connected, sets interrupt bit 5 and status bit 7, and zeroes step.
- R14: A read of slot 5 while status bit 7 is set returns the interrupt byte and then clears the interrupt and step registers, sets status to 0x02 and drops irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_mode | input | 1 | 1: word-spaced slots, 0: byte-spaced |
| bus_addr | input | ADDR_W | Register bus byte address |
| bus_wr | input | 1 | Write strobe (wins over bus_rd) |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| irq | output | 1 | Level interrupt, equals status bit 7 |
| atn | output | 1 | Attention flag |
| connected | output | 1 | Controller is connected on the bus |
| fifo_err | output | 1 | Sticky queue overflow or underflow flag |
| seq_start | output | 1 | One-cycle start strobe to the sequencer |
| seq_cmd | output | 8 | Command byte for the sequencer |
| seq_target | output | 3 | Target bus ID for selection |
| seq_done | input | 1 | Sequencer completion strobe |
| seq_fail | input | 1 | Completion ended in disconnect |
| seq_tc | input | 1 | Transfer count reached zero |
| seq_phase | input | 3 | Bus phase reported at completion |
| seq_step | input | 3 | Sequence step reported at completion |
| seq_fifo_push | input | 1 | Sequencer push into the queue |
| seq_fifo_wdata | input | 8 | Sequencer push data |
| seq_fifo_pop | input | 1 | Sequencer pop from the queue |
| seq_fifo_rdata | output | 8 | Head of the queue, 0x00 when empty |

## Verification
The assertions watch invariants that must hold on every cycle. The queue count never exceeds its depth, and a write to a full queue leaves the count unchanged. A start strobe only ever follows a command-slot write. Attention only changes after a command write. Reading the interrupt slot while the interrupt is pending drops irq on the next cycle, and chip reset clears irq, atn and the queue. The bench scenarios are the only place where the byte values are checked: the reset contents, the split read and write views, the queue order, the flag packing in slot 7, the copy of the transfer count, and the exact interrupt and status bytes after bus reset, illegal commands and sequencer results.

// File: rtl/scsi_regfront_pkg.sv
`timescale 1ns/1ps
package scsi_regfront_pkg;

    localparam int REG_SLOTS = 16;
    localparam int SLOT_W    = $clog2(REG_SLOTS);

    // slot indices
    localparam int SLOT_TC_LO   = 0;
    localparam int SLOT_TC_MID  = 1;
    localparam int SLOT_FIFO    = 2;
    localparam int SLOT_CMD     = 3;
    localparam int SLOT_STATUS  = 4;
    localparam int SLOT_IRQ     = 5;
    localparam int SLOT_STEP    = 6;
    localparam int SLOT_FLAGS   = 7;
    localparam int SLOT_CFG1    = 8;
    localparam int SLOT_CLKCONV = 9;
    localparam int SLOT_TEST    = 10;
    localparam int SLOT_CFG2    = 11;
    localparam int SLOT_CFG3    = 12;
    localparam int SLOT_TC_HI   = 14;

    // status bits
    localparam logic [7:0] STAT_INT = 8'h80;
    localparam logic [7:0] STAT_TC  = 8'h10;
    // interrupt bits
    localparam logic [7:0] INTR_BUSRST = 8'h80;
    localparam logic [7:0] INTR_ILLCMD = 8'h40;
    localparam logic [7:0] INTR_DISC   = 8'h20;
    localparam logic [7:0] INTR_BUSSVC = 8'h10;
    localparam logic [7:0] INTR_FDONE  = 8'h08;
    // config 1: reset-interrupt disable
    localparam int CFG1_RSTIRQ_OFF = 6;

    localparam logic [2:0] OWN_BUS_ID = 3'd7;
    localparam logic [2:0] PHASE_CMD  = 3'd2;

    typedef enum logic [2:0] {
        CK_NOP,
        CK_FLUSH,
        CK_CHIPRST,
        CK_BUSRST,
        CK_SETATN,
        CK_CLRATN,
        CK_SEQ,
        CK_ILLEGAL
    } cmd_kind_e;

    typedef struct packed {
        logic [REG_SLOTS-1:0][7:0] wo;     // write-side copies
        logic [23:0]               tc_rd;  // read-side transfer count
        logic [7:0]                stat;
        logic [7:0]                intr;
        logic [2:0]                step;
        logic                      atn;
        logic                      conn;
        logic                      ferr;
        logic                      start;
        logic [7:0]                start_cmd;
    } regs_t;

    function automatic regs_t regs_reset_value();
        regs_t r;
        r = '0;
        r.wo[SLOT_TC_HI]   = 8'h94;
        r.wo[SLOT_CLKCONV] = 8'h02;
        r.tc_rd            = {8'h94, 16'h0000};
        r.wo[SLOT_STEP]    = 8'h05;
        return r;
    endfunction

endpackage

// File: rtl/scsi_addr_map.sv
`timescale 1ns/1ps
module scsi_addr_map
    import scsi_regfront_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] addr,
    output logic [SLOT_W-1:0] slot,
    output logic              hit
);
    logic [ADDR_W-1:0] scaled;

    always_comb begin
        scaled = word_mode ? (addr >> 2) : addr;
        hit    = (scaled < ADDR_W'(REG_SLOTS));
        slot   = scaled[SLOT_W-1:0];
    end
endmodule

// File: rtl/scsi_cmd_class.sv
`timescale 1ns/1ps
module scsi_cmd_class
    import scsi_regfront_pkg::*;
(
    input  logic [7:0] code,
    output cmd_kind_e  kind,
    output logic       dma
);
    always_comb begin
        dma = code[7];
        case (code[6:0])
            7'h00, 7'h44: kind = CK_NOP;
            7'h01:        kind = CK_FLUSH;
            7'h02:        kind = CK_CHIPRST;
            7'h03:        kind = CK_BUSRST;
            7'h1A:        kind = CK_SETATN;
            7'h1B:        kind = CK_CLRATN;
            7'h10, 7'h11, 7'h12, 7'h18,
            7'h41, 7'h42, 7'h43, 7'h46:
                          kind = CK_SEQ;
            default:      kind = CK_ILLEGAL;
        endcase
    end
endmodule

// File: rtl/scsi_fifo.sv
`timescale 1ns/1ps
module scsi_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic                       flush,
    input  logic [W-1:0]               wdata,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t q, d;
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wp] = wdata;
                d.wp        = ptr_next(q.wp);
            end
            if (do_pop) begin
                d.rp = ptr_next(q.rp);
            end
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head  = q.mem[q.rp];
    assign count = q.cnt;
    assign full  = (q.cnt == CNT_W'(DEPTH));
    assign empty = (q.cnt == '0);
endmodule

// File: rtl/scsi_regfront.sv
`timescale 1ns/1ps
module scsi_regfront
    import scsi_regfront_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              atn,
    output logic              connected,
    output logic              fifo_err,
    output logic              seq_start,
    output logic [7:0]        seq_cmd,
    output logic [2:0]        seq_target,
    input  logic              seq_done,
    input  logic              seq_fail,
    input  logic              seq_tc,
    input  logic [2:0]        seq_phase,
    input  logic [2:0]        seq_step,
    input  logic              seq_fifo_push,
    input  logic [7:0]        seq_fifo_wdata,
    input  logic              seq_fifo_pop,
    output logic [7:0]        seq_fifo_rdata
);
    localparam int CNT_W = $clog2(FIFO_DEPTH+1);

    regs_t q, d;

    logic [SLOT_W-1:0] map_idx;
    logic              map_hit;
    cmd_kind_e         cmd_kind;
    logic              cmd_dma;
    logic              wr_act, rd_act, bus_fifo;
    logic              f_push, f_pop, f_flush;
    logic [7:0]        f_wdata, fifo_head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              fifo_full, fifo_empty;

    scsi_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .word_mode (addr_mode),
        .addr      (bus_addr),
        .slot      (map_idx),
        .hit       (map_hit)
    );

    scsi_cmd_class u_cls (
        .code (bus_wdata),
        .kind (cmd_kind),
        .dma  (cmd_dma)
    );

    scsi_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (f_push),
        .pop   (f_pop),
        .flush (f_flush),
        .wdata (f_wdata),
        .head  (fifo_head),
        .count (fifo_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    assign wr_act   = bus_wr && map_hit;
    assign rd_act   = bus_rd && !bus_wr && map_hit;
    assign bus_fifo = (wr_act || rd_act) && (map_idx == SLOT_W'(SLOT_FIFO));

    always_comb begin
        d       = q;
        d.start = 1'b0;
        f_push  = 1'b0;
        f_pop   = 1'b0;
        f_flush = 1'b0;
        f_wdata = seq_fifo_wdata;

        // queue access: the bus owns the queue in the cycle it touches slot 2
        if (bus_fifo) begin
            if (wr_act) begin
                if (fifo_full) d.ferr = 1'b1;
                else begin
                    f_push  = 1'b1;
                    f_wdata = bus_wdata;
                end
            end else if (fifo_empty) begin
                d.ferr = 1'b1;
            end else begin
                f_pop = 1'b1;
            end
        end else begin
            if (seq_fifo_push) begin
                if (fifo_full) d.ferr = 1'b1;
                else           f_push = 1'b1;
            end
            if (seq_fifo_pop) begin
                if (fifo_empty) d.ferr = 1'b1;
                else            f_pop  = 1'b1;
            end
        end

        // interrupt acknowledge by reading slot 5
        if (rd_act && map_idx == SLOT_W'(SLOT_IRQ) && q.stat[7]) begin
            d.intr = '0;
            d.step = '0;
            d.stat = {5'b0, PHASE_CMD};
        end

        // sequencer result
        if (seq_done) begin
            if (seq_fail) begin
                d.conn = 1'b0;
                d.intr = d.intr | INTR_DISC;
                d.stat = d.stat | STAT_INT;
                d.step = '0;
            end else begin
                d.conn = 1'b1;
                d.intr = d.intr | INTR_BUSSVC | INTR_FDONE;
                d.stat = {d.stat[7:3], seq_phase} | STAT_INT;
                d.step = seq_step;
                if (seq_tc) begin
                    d.stat        = d.stat | STAT_TC;
                    d.tc_rd[15:0] = '0;
                end
            end
        end

        // register writes and commands
        if (wr_act && map_idx != SLOT_W'(SLOT_FIFO)) begin
            d.wo[map_idx] = bus_wdata;
            if (map_idx == SLOT_W'(SLOT_CMD)) begin
                d.intr = d.intr & ~INTR_BUSRST;
                if (cmd_dma) begin
                    d.tc_rd = {q.wo[SLOT_TC_HI], q.wo[SLOT_TC_MID], q.wo[SLOT_TC_LO]};
                    d.stat  = d.stat & ~STAT_TC;
                end
                case (cmd_kind)
                    CK_NOP: ;
                    CK_FLUSH: f_flush = 1'b1;
                    CK_CHIPRST: begin
                        d       = regs_reset_value();
                        f_flush = 1'b1;
                    end
                    CK_BUSRST: begin
                        d.intr = d.intr | INTR_BUSRST | INTR_FDONE;
                        if (!q.wo[SLOT_CFG1][CFG1_RSTIRQ_OFF])
                            d.stat = d.stat | STAT_INT;
                        d.conn = 1'b0;
                    end
                    CK_SETATN: d.atn = 1'b1;
                    CK_CLRATN: d.atn = 1'b0;
                    CK_SEQ: begin
                        d.start     = 1'b1;
                        d.start_cmd = bus_wdata;
                    end
                    default: begin
                        d.intr = d.intr | INTR_ILLCMD;
                        d.stat = d.stat | STAT_INT;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= regs_reset_value();
        else        q <= d;
    end

    // read-side multiplexer
    always_comb begin
        bus_rdata = '0;
        if (rd_act) begin
            case (map_idx)
                SLOT_W'(SLOT_TC_LO):   bus_rdata = q.tc_rd[7:0];
                SLOT_W'(SLOT_TC_MID):  bus_rdata = q.tc_rd[15:8];
                SLOT_W'(SLOT_TC_HI):   bus_rdata = q.tc_rd[23:16];
                SLOT_W'(SLOT_FIFO):    bus_rdata = fifo_empty ? 8'h00 : fifo_head;
                SLOT_W'(SLOT_STATUS):  bus_rdata = q.stat;
                SLOT_W'(SLOT_IRQ):     bus_rdata = q.intr;
                SLOT_W'(SLOT_STEP):    bus_rdata = {5'b0, q.step};
                SLOT_W'(SLOT_FLAGS):   bus_rdata = {q.step, 5'(fifo_cnt)};
                SLOT_W'(SLOT_CFG1):    bus_rdata = {q.wo[SLOT_CFG1][7:3], OWN_BUS_ID};
                SLOT_W'(SLOT_CMD),
                SLOT_W'(SLOT_CLKCONV),
                SLOT_W'(SLOT_TEST),
                SLOT_W'(SLOT_CFG2),
                SLOT_W'(SLOT_CFG3):    bus_rdata = q.wo[map_idx];
                default:               bus_rdata = '0;
            endcase
        end
    end

    assign irq            = q.stat[7];
    assign atn            = q.atn;
    assign connected      = q.conn;
    assign fifo_err       = q.ferr;
    assign seq_start      = q.start;
    assign seq_cmd        = q.start_cmd;
    assign seq_target     = q.wo[SLOT_STATUS][2:0];
    assign seq_fifo_rdata = fifo_empty ? 8'h00 : fifo_head;
endmodule

// File: rtl/scsi_regfront_chk.sv
`timescale 1ns/1ps
module scsi_regfront_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [6:0]       cmd_code,
    input logic             reg_hit,
    input logic [3:0]       reg_idx,
    input logic             irq,
    input logic             atn,
    input logic             seq_start,
    input logic             seq_done,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             fifo_full
);
    logic cmd_wr, fifo_wr, irq_rd;
    assign cmd_wr  = wr_en && reg_hit && reg_idx == 4'd3;
    assign fifo_wr = wr_en && reg_hit && reg_idx == 4'd2;
    assign irq_rd  = rd_en && !wr_en && reg_hit && reg_idx == 4'd5;

    // R4
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    // R4
    full_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && fifo_full) |=> (fifo_cnt == CNT_W'(DEPTH)));

    // R14
    irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rd && irq && !seq_done) |=> !irq);

    // R12
    start_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> $past(cmd_wr));

    // R7
    chip_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_code == 7'h02) |=> (!irq && !atn && fifo_cnt == '0));

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(seq_done || cmd_wr));

    // R11
    atn_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(atn) |-> $past(cmd_wr));
endmodule

bind scsi_regfront scsi_regfront_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr),
    .rd_en     (bus_rd),
    .cmd_code  (bus_wdata[6:0]),
    .reg_hit   (map_hit),
    .reg_idx   (map_idx),
    .irq       (irq),
    .atn       (atn),
    .seq_start (seq_start),
    .seq_done  (seq_done),
    .fifo_cnt  (fifo_cnt),
    .fifo_full (fifo_full)
);

// File: tb/sim_scsi_regfront.sv
`timescale 1ns/1ps
module sim_scsi_regfront;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_mode = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, atn, connected, fifo_err, seq_start;
    logic [7:0] seq_cmd;
    logic [2:0] seq_target;
    logic       seq_done = 1'b0, seq_fail = 1'b0, seq_tc = 1'b0;
    logic [2:0] seq_phase = '0, seq_step = '0;
    logic       seq_fifo_push = 1'b0, seq_fifo_pop = 1'b0;
    logic [7:0] seq_fifo_wdata = '0;
    logic [7:0] seq_fifo_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    scsi_regfront u0 (
        .clk, .rst_n, .addr_mode, .bus_addr, .bus_wr, .bus_rd, .bus_wdata,
        .bus_rdata, .irq, .atn, .connected, .fifo_err, .seq_start, .seq_cmd,
        .seq_target, .seq_done, .seq_fail, .seq_tc, .seq_phase, .seq_step,
        .seq_fifo_push, .seq_fifo_wdata, .seq_fifo_pop, .seq_fifo_rdata
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic done_pulse(input logic fail, input logic tc,
                              input logic [2:0] ph, input logic [2:0] st);
        @(negedge clk);
        seq_done = 1'b1; seq_fail = fail; seq_tc = tc; seq_phase = ph; seq_step = st;
        @(posedge clk); #1;
        seq_done = 1'b0; seq_fail = 1'b0; seq_tc = 1'b0;
    endtask

    // {write, requirement number, byte address, data or expected value}
    localparam int NV = 26;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 4'd1,  8'd14, 8'h94},   // R1 count high reset
        {1'b0, 4'd1,  8'd9,  8'h02},   // R1 clock conversion reset
        {1'b0, 4'd1,  8'd8,  8'h07},   // R1 own ID
        {1'b0, 4'd1,  8'd5,  8'h00},
        {1'b0, 4'd1,  8'd4,  8'h00},
        {1'b0, 4'd1,  8'd0,  8'h00},
        {1'b1, 4'd2,  8'd8,  8'h40},   // R2 config 1, reset irq off
        {1'b0, 4'd2,  8'd8,  8'h47},
        {1'b1, 4'd2,  8'd11, 8'h5A},
        {1'b0, 4'd2,  8'd11, 8'h5A},
        {1'b1, 4'd2,  8'd12, 8'hA5},
        {1'b0, 4'd2,  8'd12, 8'hA5},
        {1'b1, 4'd3,  8'd2,  8'h11},   // R3 queue fill
        {1'b1, 4'd3,  8'd2,  8'h22},
        {1'b1, 4'd3,  8'd2,  8'h33},
        {1'b0, 4'd5,  8'd7,  8'h03},   // R5 flags
        {1'b0, 4'd3,  8'd2,  8'h11},
        {1'b0, 4'd3,  8'd2,  8'h22},
        {1'b0, 4'd3,  8'd2,  8'h33},
        {1'b0, 4'd3,  8'd2,  8'h00},   // R3 empty read
        {1'b1, 4'd9,  8'd3,  8'h03},   // R9 bus reset, irq disabled
        {1'b0, 4'd9,  8'd4,  8'h00},
        {1'b0, 4'd9,  8'd5,  8'h88},
        {1'b1, 4'd10, 8'd3,  8'h00},   // R10 nop clears bus-reset bit
        {1'b0, 4'd10, 8'd5,  8'h08},
        {1'b0, 4'd10, 8'd3,  8'h00}
    };

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got 0x00 expected 0x01");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 atn", {7'b0, atn}, 8'h00);
        chk("R1 fifo_err", {7'b0, fifo_err}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) wr(VEC[i][15:8], VEC[i][7:0]);
            else begin
                rd(VEC[i][15:8], v);
                chk($sformatf("R%0d vector %0d", VEC[i][19:16], i), v, VEC[i][7:0]);
            end
        end

        // R4 underflow in the table left the flag set
        chk("R4 sticky", {7'b0, fifo_err}, 8'h01);
        // R11
        wr(8'd3, 8'h1A);
        chk("R11 set", {7'b0, atn}, 8'h01);
        wr(8'd3, 8'h1B);
        chk("R11 clear", {7'b0, atn}, 8'h00);
        // R7
        wr(8'd3, 8'h1A);
        wr(8'd3, 8'h02);
        chk("R7 atn", {7'b0, atn}, 8'h00);
        chk("R7 fifo_err", {7'b0, fifo_err}, 8'h00);
        rd_chk("R7 cfg1", 8'd8, 8'h07);
        rd_chk("R7 intr", 8'd5, 8'h00);

        // R4 overflow: 17 pushes, last one dropped
        for (int i = 0; i < 17; i++) wr(8'd2, 8'h40 + 8'(i));
        chk("R4 overflow flag", {7'b0, fifo_err}, 8'h01);
        rd_chk("R5 full count", 8'd7, 8'h10);
        for (int i = 0; i < 16; i++) rd_chk("R3 order", 8'd2, 8'h40 + 8'(i));
        rd_chk("R5 empty count", 8'd7, 8'h00);

        // R6
        wr(8'd2, 8'h01);
        wr(8'd2, 8'h02);
        wr(8'd3, 8'h01);
        rd_chk("R6 count", 8'd7, 8'h00);
        rd_chk("R6 data", 8'd2, 8'h00);

        // R2 word-spaced addressing
        addr_mode = 1'b1;
        wr(8'd44, 8'h3C);
        rd_chk("R2 word", 8'd44, 8'h3C);
        rd_chk("R2 word low bits", 8'd47, 8'h3C);
        addr_mode = 1'b0;
        rd_chk("R2 byte view", 8'd11, 8'h3C);

        // R8
        wr(8'd0, 8'h34);
        wr(8'd1, 8'h12);
        wr(8'd14, 8'h56);
        rd_chk("R8 before lo", 8'd0, 8'h00);
        rd_chk("R8 before hi", 8'd14, 8'h94);
        wr(8'd3, 8'h80);
        rd_chk("R8 lo", 8'd0, 8'h34);
        rd_chk("R8 mid", 8'd1, 8'h12);
        rd_chk("R8 hi", 8'd14, 8'h56);

        // R12 DMA transfer handoff
        wr(8'd3, 8'h90);
        chk("R12 start", {7'b0, seq_start}, 8'h01);
        chk("R12 cmd", seq_cmd, 8'h90);
        @(posedge clk); #1;
        chk("R12 one cycle", {7'b0, seq_start}, 8'h00);
        // R13 good completion
        done_pulse(1'b0, 1'b1, 3'd1, 3'd4);
        chk("R13 irq", {7'b0, irq}, 8'h01);
        chk("R13 connected", {7'b0, connected}, 8'h01);
        rd_chk("R13 status", 8'd4, 8'h91);
        rd_chk("R13 count", 8'd0, 8'h00);
        rd_chk("R5 step field", 8'd7, 8'h80);
        // R14
        rd_chk("R14 intr", 8'd5, 8'h18);
        chk("R14 irq", {7'b0, irq}, 8'h00);
        rd_chk("R14 status", 8'd4, 8'h02);
        rd_chk("R14 step", 8'd6, 8'h00);

        // R12 selection with target, then R13 failure
        wr(8'd4, 8'h03);
        wr(8'd3, 8'h42);
        chk("R12 sel cmd", seq_cmd, 8'h42);
        chk("R12 target", {5'b0, seq_target}, 8'h03);
        done_pulse(1'b1, 1'b0, 3'd0, 3'd0);
        chk("R13 fail irq", {7'b0, irq}, 8'h01);
        rd_chk("R13 fail intr", 8'd5, 8'h20);
        chk("R13 fail conn", {7'b0, connected}, 8'h00);

        // R10 illegal
        wr(8'd3, 8'h7F);
        chk("R10 irq", {7'b0, irq}, 8'h01);
        rd_chk("R10 intr", 8'd5, 8'h40);

        // R9 with reset interrupt enabled
        wr(8'd8, 8'h00);
        wr(8'd3, 8'h03);
        chk("R9 irq", {7'b0, irq}, 8'h01);
        rd_chk("R9 intr", 8'd5, 8'h88);

        // R3 sequencer port
        @(negedge clk);
        seq_fifo_push = 1'b1; seq_fifo_wdata = 8'hAB;
        @(posedge clk); #1;
        seq_fifo_push = 1'b0;
        rd_chk("R3 seq push", 8'd2, 8'hAB);
        wr(8'd2, 8'hCD);
        chk("R3 seq head", seq_fifo_rdata, 8'hCD);
        @(negedge clk);
        seq_fifo_pop = 1'b1;
        @(posedge clk); #1;
        seq_fifo_pop = 1'b0;
        rd_chk("R3 seq pop", 8'd7, 8'h00);

        summary();
        $finish;
    end
endmodule